// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

A first-in first-out buffer for 9-bit words, written on one clock and read on an unrelated clock. Each side has a pair of enables, and an operation takes place only when both of its enables are high. The block reports four levels: empty and almost-empty on the read side, and full and almost-full on the write side. Each flag is computed in the clock domain that uses it. The pointers cross between the domains as Gray code through two-flop synchronizers.

One write-side pin has two possible roles, and the pin's level while reset is held decides which one it takes. If the pin is high during reset, it becomes the second write enable. If it is low, it becomes a strobe that writes the almost-empty and almost-full thresholds, in alternation. The read data register drives the data output, and a separate output-off input turns that output into high impedance.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low, and after it is released with no traffic, `empty` and `almost_empty` are 1, `full` and `almost_full` are 0, and `rd_data` reads 0 while `out_off` is 0.
- R2: `rd_data` is all high-impedance whenever `out_off` is 1. When `out_off` is 0, `rd_data` carries the read data register.
- R3: If `wr_en2_ld` is 1 during reset, a word is stored on a `wclk` rising edge only when `wr_en` and `wr_en2_ld` are both 1. A cycle with only one of them high stores nothing.
- R4: If `wr_en2_ld` is 0 during reset, a `wclk` edge with `wr_en`=1 and `wr_en2_ld`=1 writes `wr_data[ADDR_W:0]` to a threshold and stores no word. The target alternates, starting with the almost-empty threshold, then the almost-full threshold, then back again. A `wclk` edge with `wr_en`=1 and `wr_en2_ld`=0 stores a word.
- R5: A word is read on a `rclk` rising edge only when `rd_en` and `rd_en2` are both 1. The word appears on `rd_data` after that edge.
- R6: Words come out in the order they were written, unchanged.
- R7: A write while `full` is 1 is dropped, and the stored contents are left unchanged.
- R8: A read while `empty` is 1 is dropped. `rd_data` holds its value and no pointer moves.
- R9: `almost_empty` is 1 exactly when the stored count is at or below the almost-empty threshold. The threshold is 7 after reset.
- R10: `almost_full` is 1 exactly when the free space is at or below the almost-full threshold. The threshold is 7 after reset. With depth 16 and the default thresholds, 8 stored words clear both almost flags and 9 stored words set `almost_full`.
- R11: After a read from a full FIFO, `full` is still 1 after the first `wclk` rising edge that follows the read edge. It is 0 by the fourth such edge.
- R12: A pointer that crosses between the clock domains changes in at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, synchronous to each clock |
| wr_en | input | 1 | Primary write enable |
| wr_en2_ld | input | 1 | Second write enable or threshold strobe, role fixed during reset |
| wr_data | input | 9 | Write word; low ADDR_W+1 bits also carry a threshold value |
| rd_en | input | 1 | First read enable |
| rd_en2 | input | 1 | Second read enable |
| out_off | input | 1 | 1 puts rd_data into high impedance |
| rd_data | output | 9 | Read word |
| empty | output | 1 | No words stored (read domain) |
| almost_empty | output | 1 | Count at or below almost-empty threshold (read domain) |
| full | output | 1 | Depth words stored (write domain) |
| almost_full | output | 1 | Free space at or below almost-full threshold (write domain) |

## Verification
A read and the full flag can meet when a read from a full FIFO lands just before a write-clock edge. The bench fills the FIFO, reads one word, and then watches `full` on the write-clock edges that follow. The flag must still be set after the first edge and must be clear a few edges later. The bench also mixes threshold-load strobes with ordinary stores in the same burst. It judges the result from the flag levels and from the drained data, which must contain none of the strobe values.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  typedef enum logic {
    ROLE_WEN2 = 1'b0,
    ROLE_LOAD = 1'b1
  } pin_role_e;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // words between tail and head on a ring of 2**pw pointer values
  function automatic logic [31:0] ring_used(input logic [31:0] head,
                                            input logic [31:0] tail,
                                            input int unsigned pw);
    return (head - tail) & ((32'd1 << pw) - 32'd1);
  endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcfifo_wside.sv
module dcfifo_wside
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DEF_OFF = 7
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              we_a,
  input  logic              we2_ld,
  input  logic [ADDR_W:0]   ld_val,
  input  logic [ADDR_W:0]   rgray_s,
  output logic              mem_we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W:0]   ae_off,
  output logic              full,
  output logic              almost_full
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_V = PTR_W'(1 << ADDR_W);
  localparam logic [PTR_W-1:0] DEF_V   = PTR_W'(DEF_OFF);

  pin_role_e        role;
  logic [PTR_W-1:0] wbin, af_off, rbin_w, fill, room, wbin_nx;
  logic             sel_af, want_push, load_fire, push;
  logic [31:0]      rb32, used32, wg32;
  logic             unused_hi;

  always_comb begin
    rb32      = from_gray(32'(rgray_s));
    rbin_w    = rb32[PTR_W-1:0];
    used32    = ring_used(32'(wbin), 32'(rbin_w), PTR_W);
    fill      = used32[PTR_W-1:0];
    room      = DEPTH_V - fill;
    full      = (fill == DEPTH_V);
    almost_full = (room <= af_off);
    want_push = we_a & ((role == ROLE_WEN2) ? we2_ld : ~we2_ld);
    load_fire = we_a & (role == ROLE_LOAD) & we2_ld;
    push      = want_push & ~full;
    mem_we    = push;
    waddr     = wbin[ADDR_W-1:0];
    wbin_nx   = wbin + 1'b1;
    wg32      = to_gray(32'(wbin_nx));
  end

  assign unused_hi = ^{rb32[31:PTR_W], used32[31:PTR_W], wg32[31:PTR_W]};

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      role   <= we2_ld ? ROLE_WEN2 : ROLE_LOAD;
      wbin   <= '0;
      wgray  <= '0;
      ae_off <= DEF_V;
      af_off <= DEF_V;
      sel_af <= 1'b0;
    end else begin
      if (push) begin
        wbin  <= wbin_nx;
        wgray <= wg32[PTR_W-1:0];
      end
      if (load_fire) begin
        if (sel_af) af_off <= ld_val;
        else        ae_off <= ld_val;
        sel_af <= ~sel_af;
      end
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (want_push && full) |=> $stable(wbin));
  // R12
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));
  // R3
  role_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> $stable(role));
  // R4
  load_no_store_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    load_fire |=> $stable(wbin));
  // R10
  full_af_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);
endmodule

// File: rtl/dcfifo_rside.sv
module dcfifo_rside
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 9
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              re_a,
  input  logic              re_b,
  input  logic [ADDR_W:0]   wgray_s,
  input  logic [ADDR_W:0]   ae_off_s,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic [DATA_W-1:0] dout_q,
  output logic              empty,
  output logic              almost_empty
);
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] rbin, wbin_r, count, rbin_nx;
  logic             pop_req, pop;
  logic [31:0]      wb32, used32, rg32;
  logic             unused_hi;

  always_comb begin
    wb32    = from_gray(32'(wgray_s));
    wbin_r  = wb32[PTR_W-1:0];
    used32  = ring_used(32'(wbin_r), 32'(rbin), PTR_W);
    count   = used32[PTR_W-1:0];
    empty   = (count == '0);
    almost_empty = (count <= ae_off_s);
    pop_req = re_a & re_b;
    pop     = pop_req & ~empty;
    raddr   = rbin[ADDR_W-1:0];
    rbin_nx = rbin + 1'b1;
    rg32    = to_gray(32'(rbin_nx));
  end

  assign unused_hi = ^{wb32[31:PTR_W], used32[31:PTR_W], rg32[31:PTR_W]};

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      dout_q <= '0;
    end else if (pop) begin
      rbin   <= rbin_nx;
      rgray  <= rg32[PTR_W-1:0];
      dout_q <= rdata;
    end
  end

  // R8
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (pop_req && empty) |=> ($stable(rbin) && $stable(dout_q)));
  // R12
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));
  // R5
  one_enable_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (re_a != re_b) |=> $stable(rbin));
  // R9
  empty_ae_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 4,
  parameter int DEF_OFF = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_en2_ld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_en2,
  input  logic              out_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty,
  output logic              full,
  output logic              almost_full
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              mem_we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s, ae_off, ae_off_s;
  logic [DATA_W-1:0] rdata, dout_q;

  dcfifo_wside #(.ADDR_W(ADDR_W), .DEF_OFF(DEF_OFF)) u_w (
    .wclk(wclk), .rst_n(rst_n), .we_a(wr_en), .we2_ld(wr_en2_ld),
    .ld_val(wr_data[PTR_W-1:0]), .rgray_s(rgray_s), .mem_we(mem_we),
    .waddr(waddr), .wgray(wgray), .ae_off(ae_off), .full(full),
    .almost_full(almost_full)
  );

  always_ff @(posedge wclk) begin
    if (mem_we) mem[waddr] <= wr_data;
  end
  assign rdata = mem[raddr];

  dcfifo_sync #(.W(PTR_W)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));
  dcfifo_sync #(.W(PTR_W)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  dcfifo_sync #(.W(PTR_W), .RST_VAL(PTR_W'(DEF_OFF))) u_off (
    .clk(rclk), .rst_n(rst_n), .d(ae_off), .q(ae_off_s));

  dcfifo_rside #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_r (
    .rclk(rclk), .rst_n(rst_n), .re_a(rd_en), .re_b(rd_en2),
    .wgray_s(wgray_s), .ae_off_s(ae_off_s), .rdata(rdata), .raddr(raddr),
    .rgray(rgray), .dout_q(dout_q), .empty(empty),
    .almost_empty(almost_empty)
  );

  assign rd_data = out_off ? {DATA_W{1'bz}} : dout_q;
endmodule

// File: tb/sim_dcfifo_pflag.sv
`timescale 1ns/100ps
module sim_dcfifo_pflag;
  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_en2_ld = 1'b1, rd_en = 1'b0, rd_en2 = 1'b0, out_off = 1'b0;
  logic [8:0] wr_data = '0;
  wire  [8:0] rd_data;
  wire  empty, almost_empty, full, almost_full;
  int checks = 0, fails = 0;

  dcfifo_pflag u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_en2_ld(wr_en2_ld), .wr_data(wr_data), .rd_en(rd_en), .rd_en2(rd_en2),
    .out_off(out_off), .rd_data(rd_data), .empty(empty),
    .almost_empty(almost_empty), .full(full), .almost_full(almost_full)
  );

  always #5 wclk = ~wclk;
  initial begin
    #1.5;
    forever #7 rclk = ~rclk;
  end

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pin);
    rst_n = 1'b0; wr_en = 0; rd_en = 0; rd_en2 = 0; wr_en2_ld = pin;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    rst_n = 1'b1;
  endtask

  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (5) @(negedge wclk);
  endtask

  task automatic push(input logic [8:0] d);
    @(negedge wclk);
    wr_en = 1'b1; wr_data = d;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic pop_en(input logic a, input logic b);
    @(negedge rclk);
    rd_en = a; rd_en2 = b;
    @(negedge rclk);
    rd_en = 1'b0; rd_en2 = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    check("R1 empty", {8'd0, empty}, 9'd1);
    check("R1 almost_empty", {8'd0, almost_empty}, 9'd1);
    check("R1 full", {8'd0, full}, 9'd0);
    check("R1 almost_full", {8'd0, almost_full}, 9'd0);
    check("R1 rd_data", rd_data, 9'd0);
    settle();
    check("R1 empty after release", {8'd0, empty}, 9'd1);
    out_off = 1'b1; #1;
    check("R2 high-Z", rd_data, 9'bzzzzzzzzz);
    out_off = 1'b0; #1;
    check("R2 driven", rd_data, 9'd0);
  endtask

  task automatic t_enables();
    wr_en2_ld = 1'b0;
    push(9'h055);
    settle();
    check("R3 single enable stores nothing", {8'd0, empty}, 9'd1);
    wr_en2_ld = 1'b1;
    push(9'h1A3);
    settle();
    check("R3 both enables store", {8'd0, empty}, 9'd0);
    pop_en(1'b1, 1'b0);
    pop_en(1'b0, 1'b1);
    check("R5 one read enable no read", rd_data, 9'd0);
    pop_en(1'b1, 1'b1);
    check("R5 read data", rd_data, 9'h1A3);
    settle();
    check("R5 empty after read", {8'd0, empty}, 9'd1);
    pop_en(1'b1, 1'b1);
    check("R8 read on empty holds data", rd_data, 9'h1A3);
    push(9'h0F0);
    settle();
    pop_en(1'b1, 1'b1);
    check("R8 no pointer slip", rd_data, 9'h0F0);
  endtask

  task automatic t_fill();
    do_reset(1'b1);
    settle();
    for (int i = 0; i < 16; i++) begin
      push(9'((i * 37 + 5) & 9'h1FF));
      if (i == 6) begin
        settle();
        check("R9 ae at 7", {8'd0, almost_empty}, 9'd1);
      end
      if (i == 7) begin
        settle();
        check("R9 ae clear at 8", {8'd0, almost_empty}, 9'd0);
        check("R10 af clear at 8", {8'd0, almost_full}, 9'd0);
      end
      if (i == 8) begin
        settle();
        check("R10 af at 9", {8'd0, almost_full}, 9'd1);
      end
    end
    settle();
    check("R7 full at depth", {8'd0, full}, 9'd1);
    push(9'h1FF);
    settle();
    check("R7 still full", {8'd0, full}, 9'd1);
    // R12 and R6: data crosses domains in order
    for (int i = 0; i < 16; i++) begin
      pop_en(1'b1, 1'b1);
      check("R6 order", rd_data, 9'((i * 37 + 5) & 9'h1FF));
    end
    pop_en(1'b1, 1'b1);
    check("R7 dropped word absent", rd_data, 9'((15 * 37 + 5) & 9'h1FF));
    settle();
    check("R7 empty after drain", {8'd0, empty}, 9'd1);
  endtask

  task automatic t_skew();
    do_reset(1'b1);
    settle();
    for (int i = 0; i < 16; i++) push(9'(i + 9'h40));
    settle();
    check("R11 full before read", {8'd0, full}, 9'd1);
    @(negedge rclk);
    rd_en = 1'b1; rd_en2 = 1'b1;
    @(posedge rclk);
    #1;
    rd_en = 1'b0; rd_en2 = 1'b0;
    @(posedge wclk);
    #1;
    check("R11 full after first wclk edge", {8'd0, full}, 9'd1);
    repeat (3) @(posedge wclk);
    #1;
    check("R11 full cleared", {8'd0, full}, 9'd0);
    check("R11 read word", rd_data, 9'h40);
  endtask

  task automatic t_load();
    do_reset(1'b0);
    wr_en2_ld = 1'b0;
    settle();
    wr_en2_ld = 1'b1;
    push(9'd2);
    push(9'd3);
    wr_en2_ld = 1'b0;
    for (int i = 0; i < 13; i++) begin
      push(9'(9'h100 + i));
      if (i == 1) begin
        settle();
        check("R4 ae at count 2 thr 2", {8'd0, almost_empty}, 9'd1);
      end
      if (i == 2) begin
        settle();
        check("R4 ae clear at 3", {8'd0, almost_empty}, 9'd0);
      end
      if (i == 11) begin
        settle();
        check("R4 af clear at 12 thr 3", {8'd0, almost_full}, 9'd0);
      end
    end
    settle();
    check("R4 af at 13", {8'd0, almost_full}, 9'd1);
    wr_en2_ld = 1'b1;
    push(9'd13);
    wr_en2_ld = 1'b0;
    settle();
    check("R4 wrap to ae threshold", {8'd0, almost_empty}, 9'd1);
    check("R4 af threshold unchanged", {8'd0, almost_full}, 9'd1);
    for (int i = 0; i < 13; i++) begin
      pop_en(1'b1, 1'b1);
      check("R4 stored data excludes loads", rd_data, 9'(9'h100 + i));
    end
    settle();
    check("R4 empty after drain", {8'd0, empty}, 9'd1);
  endtask

  initial begin
    t_reset();
    t_enables();
    t_fill();
    t_skew();
    t_load();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule